// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block paces the housekeeping of an asynchronous 16-bit DRAM from a free-running clock. After reset it keeps the memory closed to user traffic. It first counts out a start-up wait, then asks the access sequencer for a burst of wake-up refresh cycles. Only when every cycle of that burst has been granted does it raise `ready`. All requests are CAS-before-RAS refreshes, so the sequencer holds write-enable high and drives no row address; the DRAM's internal row counter supplies it.

In normal operation a slot timer asks for one refresh per refresh interval. Each request is held until the sequencer grants it. If a request waits ungranted for a whole refresh period, the stored contents can no longer be trusted to be kept. The block then sets a sticky `overrun` flag, drops `ready`, and runs the full wake-up burst again before it reopens the memory.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ref_req`, `ref_wake`, `ready` and `overrun` are all 0.
- R2: The first `ref_req` rises exactly `WAIT_CYCLES` clock cycles after the first rising edge with `rst` low, and `ready` stays 0 until then.
- R3: During a wake-up burst `ref_req` and `ref_wake` stay 1 until `WAKE_COUNT` grants have been accepted. In the cycle after the last grant, `ref_req` and `ref_wake` fall and `ready` rises.
- R4: A grant is accepted only on an edge where both `ref_req` and `ref_grant` are 1. `ref_grant` held high while `ref_req` is 0 (for example during the start-up wait) does not shorten the following burst.
- R5: Once `ready` is 1, a refresh request rises every `REFI_CYCLES` cycles, counted from the edge that raised `ready`, whatever the grant latency (below one interval).
- R6: A normal refresh request stays 1 while ungranted and falls in the cycle after its grant, with `ref_wake` at 0.
- R7: If a grant is accepted on the same edge on which a new interval expires, `ref_req` stays 1 for the new interval's request, which then needs its own grant.
- R8: If a pending request sees no grant for `OVR_CYCLES` cycles, then `OVR_CYCLES` cycles after `ref_req` rose, `overrun` and `ref_wake` become 1, `ready` becomes 0 and `ref_req` stays 1.
- R9: `overrun` stays 1 until reset. After an overrun, `ready` returns only after a complete new burst of `WAKE_COUNT` grants.
- R10: A grant accepted on the last edge before the overrun deadline clears the request without setting `overrun` or dropping `ready`.
- R11: While `ref_wake` is 1, `ready` is 0. Gaps in the grant stream only stretch the burst: with grants on alternate cycles, `ready` rises `2*WAKE_COUNT-1` cycles after the first grant is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | output | 1 | Refresh request to the sequencer (CAS-before-RAS, WE high) |
| ref_grant | input | 1 | Sequencer accepts the pending request on this edge |
| ref_wake | output | 1 | Current request belongs to a wake-up burst |
| ready | output | 1 | User accesses may be issued |
| overrun | output | 1 | Sticky: a refresh period was exceeded since reset |

## Verification
Two pairs of events can land on the same edge. In the first, a grant arrives exactly when the slot timer expires. The bench provokes this by holding a request for `REFI_CYCLES-1` cycles before granting it, and judges it by `ref_req` staying high for one more grant. In the second, a grant arrives on the final edge of the overrun window. The bench aligns the grant so the pending request has waited `OVR_CYCLES-1` cycles, then expects `overrun` low and `ready` high. A later request left ungranted must then trigger the burst at exactly `OVR_CYCLES` cycles.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_WAKE = 2'd1,
    PH_RUN  = 2'd2
  } sched_phase_e;
endpackage

// File: rtl/sched_tick.sv
// Wrapping cycle counter: tick is high in the enabled cycle that ends a
// LIMIT-long span; clr has priority and returns the count to zero.
module sched_tick #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sched_burst.sv
// Counts the grants still owed in a wake-up burst.
module sched_burst #(
  parameter int WAKE_COUNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic done
);
  localparam int BW = $clog2(WAKE_COUNT + 1);
  localparam logic [BW-1:0] FULL = BW'(WAKE_COUNT);

  logic [BW-1:0] left_q;

  assign done = dec && (left_q == BW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= FULL;
    end else if (dec && left_q != '0) begin
      left_q <= left_q - BW'(1);
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_sched_pkg::*;
#(
  parameter int WAIT_CYCLES = 10000,
  parameter int REFI_CYCLES = 1562,
  parameter int OVR_CYCLES  = 1600000,
  parameter int WAKE_COUNT  = 8
) (
  input  logic clk,
  input  logic rst,
  output logic ref_req,
  input  logic ref_grant,
  output logic ref_wake,
  output logic ready,
  output logic overrun
);
  sched_phase_e phase_q, phase_d;
  logic pend_q, pend_d;
  logic ovr_d;
  logic grant_ok;
  logic wait_tick, slot_tick, age_tick, burst_done, burst_load;
  logic in_run;

  assign grant_ok = ref_req && ref_grant;
  assign in_run   = (phase_q == PH_RUN);

  sched_tick #(.LIMIT(WAIT_CYCLES)) u_wait (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .en  (phase_q == PH_WAIT),
    .tick(wait_tick)
  );

  sched_tick #(.LIMIT(REFI_CYCLES)) u_slot (
    .clk (clk),
    .rst (rst),
    .clr (!in_run),
    .en  (in_run),
    .tick(slot_tick)
  );

  sched_tick #(.LIMIT(OVR_CYCLES)) u_age (
    .clk (clk),
    .rst (rst),
    .clr (!in_run || !pend_q || grant_ok),
    .en  (in_run && pend_q && !grant_ok),
    .tick(age_tick)
  );

  sched_burst #(.WAKE_COUNT(WAKE_COUNT)) u_burst (
    .clk (clk),
    .rst (rst),
    .load(burst_load),
    .dec (grant_ok && phase_q == PH_WAKE),
    .done(burst_done)
  );

  always_comb begin
    phase_d    = phase_q;
    pend_d     = pend_q;
    ovr_d      = overrun;
    burst_load = 1'b0;
    unique case (phase_q)
      PH_WAIT: begin
        if (wait_tick) begin
          phase_d    = PH_WAKE;
          burst_load = 1'b1;
        end
      end
      PH_WAKE: begin
        pend_d = 1'b0;
        if (burst_done) phase_d = PH_RUN;
      end
      PH_RUN: begin
        if (age_tick) begin
          phase_d    = PH_WAKE;
          burst_load = 1'b1;
          ovr_d      = 1'b1;
          pend_d     = 1'b0;
        end else begin
          pend_d = slot_tick || (pend_q && !grant_ok);
        end
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_WAIT;
      pend_q   <= 1'b0;
      ref_req  <= 1'b0;
      ref_wake <= 1'b0;
      ready    <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      pend_q   <= pend_d;
      ref_req  <= (phase_d == PH_WAKE) || pend_d;
      ref_wake <= (phase_d == PH_WAKE);
      ready    <= (phase_d == PH_RUN);
      overrun  <= ovr_d;
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int WAIT_CYCLES = 10000
) (
  input logic clk,
  input logic rst,
  input logic ref_req,
  input logic ref_grant,
  input logic ref_wake,
  input logic ready,
  input logic overrun
);
  localparam int SW = $clog2(WAIT_CYCLES + 1);
  localparam logic [SW-1:0] SAT = SW'(WAIT_CYCLES);

  logic [SW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)              since_rst <= '0;
    else if (since_rst != SAT) since_rst <= since_rst + SW'(1);
  end

  AST_WAIT_HONOURED: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> (since_rst == SAT)); // R2

  AST_READY_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(ref_wake) && $past(ref_grant))); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant) |=> ref_req); // R6

  AST_OVR_BURST: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> (ref_wake && !ready)); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R9

  AST_WAKE_GATES: assert property (@(posedge clk) disable iff (rst)
    ref_wake |-> (!ready && ref_req)); // R11
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_req  (ref_req),
  .ref_grant(ref_grant),
  .ref_wake (ref_wake),
  .ready    (ready),
  .overrun  (overrun)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int W    = 20;
  localparam int REFI = 10;
  localparam int OVR  = 35;
  localparam int WK   = 8;
  localparam int NDLY = 5;
  localparam int DLY [NDLY] = '{0, 2, 5, 8, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_grant = 1'b0;
  logic ref_req, ref_wake, ready, overrun;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .WAIT_CYCLES(W), .REFI_CYCLES(REFI), .OVR_CYCLES(OVR), .WAKE_COUNT(WK)
  ) u0 (
    .clk(clk), .rst(rst), .ref_req(ref_req), .ref_grant(ref_grant),
    .ref_wake(ref_wake), .ready(ready), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int k;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_eq("R1 ref_req", ref_req, 0);
    chk_eq("R1 ref_wake", ref_wake, 0);
    chk_eq("R1 ready", ready, 0);
    chk_eq("R1 overrun", overrun, 0);

    // R2 start-up wait, grant held high throughout (R4: must be ignored)
    rst = 1'b0;
    ref_grant = 1'b1;
    n = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R2 wait length", n, W);
    chk_eq("R2 ready during wait", ready, 0);
    chk_eq("R3 wake flag", ref_wake, 1);

    // R3/R4 burst with grant held high
    n = 0;
    while (ref_req && n < 100) begin @(negedge clk); n++; end
    chk_eq("R4 burst grants", n, WK);
    chk_eq("R3 ready after burst", ready, 1);
    chk_eq("R3 wake low after burst", ref_wake, 0);
    ref_grant = 1'b0;

    // R5 first slot
    n = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R5 first slot", n, REFI);

    // Table of grant latencies: R6 hold, R5 fixed pacing
    for (int i = 0; i < NDLY; i++) begin
      repeat (DLY[i]) begin
        @(negedge clk);
        chk_eq("R6 held while ungranted", ref_req, 1);
      end
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      chk_eq("R6 dropped after grant", ref_req, 0);
      chk_eq("R6 wake low", ref_wake, 0);
      n = DLY[i] + 1;
      while (!ref_req && n < 1000) begin @(negedge clk); n++; end
      chk_eq("R5 slot spacing", n, REFI);
    end

    // R7 grant coinciding with slot expiry
    repeat (REFI - 1) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk_eq("R7 new request kept", ref_req, 1);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk_eq("R7 second grant clears", ref_req, 0);
    n = 1;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R5 spacing after coincidence", n, REFI);

    // R10 grant on the last edge before the deadline
    repeat (OVR - 1) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    chk_eq("R10 no overrun", overrun, 0);
    chk_eq("R10 ready kept", ready, 1);
    chk_eq("R10 request cleared", ref_req, 0);
    n = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R5 spacing after long wait", n, ((OVR / REFI) + 1) * REFI - OVR);

    // R8 overrun
    n = 0;
    while (!ref_wake && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R8 overrun delay", n, OVR);
    chk_eq("R8 overrun flag", overrun, 1);
    chk_eq("R8 ready dropped", ready, 0);
    chk_eq("R8 request kept", ref_req, 1);

    // R11/R9 repeated burst with alternate-cycle grants
    n = 0;
    k = 0;
    while (!ready && n < 200) begin
      ref_grant = (n % 2 == 0);
      if (ref_req && ref_grant) k++;
      @(negedge clk);
      n++;
      if (!ready) chk_eq("R11 wake during burst", ref_wake, 1);
    end
    ref_grant = 1'b0;
    chk_eq("R11 grants in gapped burst", k, WK);
    chk_eq("R11 gapped burst length", n, 2 * WK - 1);
    chk_eq("R9 overrun sticky", overrun, 1);
    chk_eq("R9 wake ended", ref_wake, 0);

    // R9/R1 overrun clears only by reset
    rst = 1'b1;
    @(negedge clk);
    chk_eq("R9 overrun cleared by reset", overrun, 0);
    chk_eq("R1 ready in reset", ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 request after reset", ref_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule